// File: doc/BRIEF.md
# Receive Character Gate with Match Detection

This block sits between the character output of a serial receiver and a small first-in first-out receive buffer, and decides which characters are kept. Two programmable match values are held in one 32-bit word. When the gated mode is on, the first match value opens a gate and the second closes it. Characters that arrive while the gate is closed are dropped.

Each match value has its own flag. A flag sets only when a character equal to that value is actually written into the buffer. Each flag can raise the interrupt output when its own interrupt enable is set. The buffer holds four characters. A character that should be stored while the buffer is full is dropped and an overrun flag is raised. Software reads the oldest character at the output, pops it, and clears flags by writing ones.

Top module: `rxm_gate_top`

## Requirements
- R1: After reset the buffer is empty (`empty`=1, `count`=0), all three flags and `irq` are 0, and the gate is closed.
- R2: A write on `mreg_wr` loads match value A from bits 15:0 and match value B from bits 31:16. A character matches when its zero-extended 16-bit value equals the half-word. The write takes effect only while both match enables are clear; otherwise it is ignored.
- R3: The control word is written through `ctrl_wr`. Bit 0 enables match A, bit 1 enables match B, bit 2 selects gated mode, bit 3 is the interrupt enable for A and bit 4 is the interrupt enable for B. With bit 2 clear, every character is stored. Characters are read out in arrival order, and `rd_data` shows the oldest one whenever `empty` is 0.
- R4: In gated mode with the gate closed, characters are discarded. A character equal to match A while match A is enabled opens the gate, is stored, and sets `flag_a`.
- R5: In gated mode with the gate open and match B enabled, a character equal to match B is not stored, closes the gate, and leaves `flag_b` clear. The characters that follow are discarded.
- R6: With match B disabled, a character equal to match B is stored and sets `flag_b`, and storing continues. More generally, a flag sets whenever the character just stored equals its match value.
- R7: `irq` is 1 exactly when (`flag_a` and the A interrupt enable) or (`flag_b` and the B interrupt enable). An interrupt enable with its flag clear gives no interrupt.
- R8: The buffer holds 4 characters. A character that should be stored while 4 are held, with no pop in the same cycle, is dropped, the stored contents are kept, and `flag_ovr` sets.
- R9: `flag_clr` clears flags by writing 1: bit 0 clears `flag_a`, bit 1 clears `flag_b`, bit 2 clears `flag_ovr`. If a flag is set and cleared in the same cycle, the set wins.
- R10: A pop while `empty` is 1 has no effect on `count` or on the contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Strobe for a received character |
| rx_char | input | 8 | Received character |
| mreg_wr | input | 1 | Write strobe for the match word |
| mreg_wdata | input | 32 | Match word: A in bits 15:0, B in bits 31:16 |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 5 | Control word (see R3) |
| flag_clr | input | 3 | Write-1-to-clear pulses for A, B and overrun |
| pop | input | 1 | Removes the oldest buffered character |
| rd_data | output | 8 | Oldest buffered character |
| empty | output | 1 | Buffer holds nothing |
| count | output | 3 | Number of characters held |
| flag_a | output | 1 | Match A flag |
| flag_b | output | 1 | Match B flag |
| flag_ovr | output | 1 | Overrun flag |
| irq | output | 1 | Match interrupt request |

## Verification
The assertions assume that inputs are stable around the rising edge and that `rx_valid` is a single-cycle pulse for each character. They also assume the match word is rewritten only with both enables clear, which the block enforces itself. The stimulus changes every input on the falling edge and holds each strobe for exactly one cycle. Every write to the match word in the bench is made with the enables cleared, except for the one write that is meant to be rejected.

// File: rtl/rxm_pkg.sv
package rxm_pkg;

  localparam int CHAR_W = 8;
  localparam int HALF_W = 16;

  typedef struct packed {
    logic ie_b;
    logic ie_a;
    logic gated;
    logic en_b;
    logic en_a;
  } rxm_ctrl_t;

  typedef struct packed {
    logic keep;
    logic gate_nxt;
  } rxm_dec_t;

  function automatic logic rxm_hit(input logic [CHAR_W-1:0] c,
                                   input logic [HALF_W-1:0] mv);
    return ({{(HALF_W-CHAR_W){1'b0}}, c} == mv);
  endfunction

  // Store/gate decision for one received character.
  function automatic rxm_dec_t rxm_decide(input logic gated, input logic en_a,
                                          input logic en_b, input logic gate,
                                          input logic hit_a, input logic hit_b);
    rxm_dec_t d;
    d.keep     = 1'b1;
    d.gate_nxt = gate;
    if (gated) begin
      if (!gate) begin
        d.keep     = en_a && hit_a;
        d.gate_nxt = en_a && hit_a;
      end else if (en_b && hit_b) begin
        d.keep     = 1'b0;
        d.gate_nxt = 1'b0;
      end
    end
    return d;
  endfunction

endpackage

// File: rtl/rxm_match.sv
module rxm_match
  import rxm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              mreg_wr,
  input  logic [31:0]       mreg_wdata,
  input  logic              gated,
  input  logic              en_a,
  input  logic              en_b,
  output logic              store_req,
  output logic              hit_a,
  output logic              hit_b,
  output logic              gate_open
);

  logic [31:0] mreg;
  logic        mreg_ok;
  rxm_dec_t    dec;

  assign mreg_ok = mreg_wr && !en_a && !en_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mreg <= '0;
    else if (mreg_ok) mreg <= mreg_wdata;
  end

  assign hit_a     = rxm_hit(rx_char, mreg[HALF_W-1:0]);
  assign hit_b     = rxm_hit(rx_char, mreg[2*HALF_W-1:HALF_W]);
  assign dec       = rxm_decide(gated, en_a, en_b, gate_open, hit_a, hit_b);
  assign store_req = rx_valid && dec.keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gate_open <= 1'b0;
    else if (rx_valid) gate_open <= dec.gate_nxt;
  end

  a_r2_match_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (en_a || en_b) |=> $stable(mreg));

  a_r4_closed_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && gated && !gate_open && !(en_a && hit_a)) |-> !store_req);

  a_r5_close_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && gated && en_b && hit_b) |=> !gate_open);

endmodule

// File: rtl/rxm_fifo.sv
module rxm_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic          push_ok,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          pop_ok;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= nxt(wp);
      if (pop_ok)  rp <= nxt(rp);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  a_r8_count_max: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  a_r8_full_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> $stable(count) && $stable(rdata));

  a_r10_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> empty);

endmodule

// File: rtl/rxm_gate_top.sv
module rxm_gate_top
  import rxm_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_char,
  input  logic              mreg_wr,
  input  logic [31:0]       mreg_wdata,
  input  logic              ctrl_wr,
  input  logic [4:0]        ctrl_wdata,
  input  logic [2:0]        flag_clr,
  input  logic              pop,
  output logic [7:0]        rd_data,
  output logic              empty,
  output logic [CW-1:0]     count,
  output logic              flag_a,
  output logic              flag_b,
  output logic              flag_ovr,
  output logic              irq
);

  rxm_ctrl_t ctrl;
  logic store_req, hit_a, hit_b, gate_open;
  logic push_ok, full, ovr_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= '0;
    else if (ctrl_wr) ctrl <= rxm_ctrl_t'(ctrl_wdata);
  end

  rxm_match u_match (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
    .mreg_wr(mreg_wr), .mreg_wdata(mreg_wdata),
    .gated(ctrl.gated), .en_a(ctrl.en_a), .en_b(ctrl.en_b),
    .store_req(store_req), .hit_a(hit_a), .hit_b(hit_b), .gate_open(gate_open)
  );

  rxm_fifo #(.DEPTH(DEPTH), .W(CHAR_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(store_req), .wdata(rx_char), .pop(pop),
    .push_ok(push_ok), .rdata(rd_data), .count(count), .empty(empty), .full(full)
  );

  assign ovr_evt = store_req && !push_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_a   <= 1'b0;
      flag_b   <= 1'b0;
      flag_ovr <= 1'b0;
    end else begin
      flag_a   <= (flag_a   && !flag_clr[0]) || (push_ok && hit_a);
      flag_b   <= (flag_b   && !flag_clr[1]) || (push_ok && hit_b);
      flag_ovr <= (flag_ovr && !flag_clr[2]) || ovr_evt;
    end
  end

  assign irq = (flag_a && ctrl.ie_a) || (flag_b && ctrl.ie_b);

  a_r6_flag_a_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_a) |-> $past(push_ok && hit_a));

  a_r5_b_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.gated && ctrl.en_b && hit_b) |-> !push_ok);

  a_r8_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (store_req && full && !pop) |=> flag_ovr);

  a_r7_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_a && !flag_b) |-> !irq);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_ovr && !flag_clr[2]) |=> flag_ovr);

endmodule

// File: tb/sim_rxm_gate_top.sv
module sim_rxm_gate_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_char = '0;
  logic        mreg_wr = 1'b0;
  logic [31:0] mreg_wdata = '0;
  logic        ctrl_wr = 1'b0;
  logic [4:0]  ctrl_wdata = '0;
  logic [2:0]  flag_clr = '0;
  logic        pop = 1'b0;
  logic [7:0]  rd_data;
  logic        empty;
  logic [2:0]  count;
  logic        flag_a, flag_b, flag_ovr, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rxm_gate_top u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
    .mreg_wr(mreg_wr), .mreg_wdata(mreg_wdata), .ctrl_wr(ctrl_wr),
    .ctrl_wdata(ctrl_wdata), .flag_clr(flag_clr), .pop(pop),
    .rd_data(rd_data), .empty(empty), .count(count), .flag_a(flag_a),
    .flag_b(flag_b), .flag_ovr(flag_ovr), .irq(irq)
  );

  // {expected stored, character}; gated mode, A='1', B='2', both enabled
  localparam logic [8:0] TBL [9] = '{
    {1'b0, 8'h61}, {1'b1, 8'h31}, {1'b1, 8'h62}, {1'b1, 8'h63}, {1'b0, 8'h32},
    {1'b0, 8'h64}, {1'b1, 8'h31}, {1'b1, 8'h65}, {1'b0, 8'h32}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic send(input logic [7:0] c, input logic [2:0] clr = 3'b000);
    @(negedge clk); rx_valid = 1'b1; rx_char = c; flag_clr = clr;
    @(negedge clk); rx_valid = 1'b0; flag_clr = '0;
  endtask

  task automatic wr_ctrl(input logic [4:0] v);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic wr_mreg(input logic [31:0] v);
    @(negedge clk); mreg_wr = 1'b1; mreg_wdata = v;
    @(negedge clk); mreg_wr = 1'b0;
  endtask

  task automatic clr(input logic [2:0] v);
    @(negedge clk); flag_clr = v;
    @(negedge clk); flag_clr = '0;
  endtask

  task automatic do_pop;
    @(negedge clk); pop = 1'b1;
    @(negedge clk); pop = 1'b0;
  endtask

  task automatic pop_expect(input string req, input logic [7:0] c);
    eq(req, int'(rd_data), int'(c));
    do_pop();
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    eq("R1 empty", int'(empty), 1);
    eq("R1 count", int'(count), 0);
    eq("R1 flags", int'({flag_a, flag_b, flag_ovr}), 0);
    eq("R1 irq", int'(irq), 0);

    // R2 match load and write lock
    wr_ctrl(5'h00);
    wr_mreg(32'h0032_0031);
    wr_ctrl(5'h01);
    wr_mreg(32'h0000_0034);       // rejected: match A enabled
    wr_ctrl(5'h00);
    send(8'h34);
    eq("R2 locked write ignored", int'(flag_a), 0);
    pop_expect("R3 pass-through store", 8'h34);
    send(8'h31);
    eq("R2 low half is match A", int'(flag_a), 1);
    do_pop();
    clr(3'b111);
    eq("R9 clear all", int'({flag_a, flag_b, flag_ovr}), 0);

    // R1 gate starts closed; R4/R5 table walk
    wr_ctrl(5'h07);
    foreach (TBL[i]) begin
      send(TBL[i][7:0]);
      if (TBL[i][8]) begin
        eq("R4 gate open stores", int'(empty), 0);
        pop_expect("R4 stored char", TBL[i][7:0]);
      end else begin
        eq("R5 discard while closed", int'(count), 0);
      end
    end
    eq("R4 flag_a set", int'(flag_a), 1);
    eq("R5 flag_b clear when B discarded", int'(flag_b), 0);

    // R6 match B disabled
    wr_ctrl(5'h05);
    send(8'h71);
    eq("R4 closed gate drops", int'(count), 0);
    send(8'h31);
    send(8'h32);
    eq("R6 flag_b set on stored B", int'(flag_b), 1);
    send(8'h7a);
    eq("R6 storing continues", int'(count), 3);
    pop_expect("R3 order 1", 8'h31);
    pop_expect("R3 order 2", 8'h32);
    pop_expect("R3 order 3", 8'h7a);

    // R7 interrupt gating
    clr(3'b001);
    wr_ctrl(5'h0D);
    eq("R7 enable alone no irq", int'(irq), 0);
    wr_ctrl(5'h15);
    eq("R7 flag_b with enable", int'(irq), 1);
    clr(3'b010);
    eq("R7 irq drops after clear", int'(irq), 0);

    // R8 overrun
    wr_ctrl(5'h00);
    send(8'h41); send(8'h42); send(8'h43); send(8'h44);
    eq("R8 full count", int'(count), 4);
    eq("R8 no overrun yet", int'(flag_ovr), 0);
    send(8'h45);
    eq("R8 overrun flag", int'(flag_ovr), 1);
    eq("R8 count kept", int'(count), 4);
    send(8'h46, 3'b100);
    eq("R9 set wins over clear", int'(flag_ovr), 1);
    clr(3'b100);
    eq("R9 overrun cleared", int'(flag_ovr), 0);
    pop_expect("R8 kept 1", 8'h41);
    pop_expect("R8 kept 2", 8'h42);
    pop_expect("R8 kept 3", 8'h43);
    pop_expect("R8 kept 4", 8'h44);
    eq("R8 drained", int'(empty), 1);

    // R10 pop on empty
    do_pop();
    eq("R10 count stays 0", int'(count), 0);
    eq("R10 still empty", int'(empty), 1);
    send(8'h47);
    eq("R10 later push count", int'(count), 1);
    pop_expect("R10 later push data", 8'h47);

    done = 1;
    summary();
  end

endmodule